// File: doc/BRIEF.md
# Multicart PRG/CHR Bank Address Generator

This block turns the CPU address window $8000-$FFFF, together with the current mapper register fields, into a 7-bit 16K PRG-ROM bank number and a 21-bit PRG-ROM byte address. It also passes through the 8K CHR bank number and produces the nametable select line (CIRAM A10). It supports three discrete PRG layouts inside a game-sized outer window:

- one 32K switchable window;
- 16K switchable at the top with the bottom fixed;
- 16K switchable at the bottom with the top fixed.

The bank is formed in two stages. The first stage picks a 4-bit inner bank according to the layout. The second stage merges that inner bank with the outer bank through AND masks that depend on the game size.

The layout is a decoded mode with three named values:

| Mode | Selected when | Behaviour |
|------|---------------|-----------|
| `PM_32K` | size bit clear | 32K switchable window |
| `PM_16K_LOWFIX` | size bit set, slot 0 | low half fixed, high half switchable |
| `PM_16K_HIFIX` | size bit set, slot 1 | high half fixed, low half switchable |

The mode is re-evaluated from the inputs every cycle, so there are no transitions beyond this selection. Mirroring uses four named codes: `NT_ONE_A`, `NT_ONE_B`, `NT_VERT` and `NT_HORZ`.

All outputs are registered once. Each output shows the result for the inputs sampled at the previous rising clock edge.

Top module: `mcart_bank_gen`

## Requirements
- R1: While rst_n is low, and on the first clock after it rises, every output reads zero.
- R2: Apart from reset, every output at a rising edge equals the translation of the inputs present at the preceding rising edge (one cycle of latency).
- R3: With prg_16k = 0 (`PM_32K`), the inner bank is {inner_prg[2:0], cpu_addr[14]}; inner_prg[3] has no effect.
- R4: With prg_16k = 1 and slot_sel = 0 (`PM_16K_LOWFIX`), the inner bank is inner_prg when cpu_addr[14] = 1, and {outer_prg[2:0], 0} when cpu_addr[14] = 0.
- R5: With prg_16k = 1 and slot_sel = 1 (`PM_16K_HIFIX`), the inner bank is inner_prg when cpu_addr[14] = 0, and {outer_prg[2:0], 1} when cpu_addr[14] = 1.
- R6: With prg_16k = 0, slot_sel has no effect on any output.
- R7: prg_bank = (inner AND imask) OR ((outer_prg shifted left by one) AND omask). For game_size 0, 1, 2 and 3, imask is 0x01, 0x03, 0x07 and 0x0F, and omask is 0x7E, 0x7C, 0x78 and 0x70.
- R8: prg_addr equals {prg_bank, cpu_addr[13:0]}.
- R9: chr_bank equals chr_reg.
- R10: ciram_a10 depends on mirror. Code 0 gives 0, code 1 gives 1, code 2 gives ppu_a10, and code 3 gives ppu_a11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 15 | CPU A14:A0 within the $8000-$FFFF window |
| ppu_a10 | input | 1 | PPU address bit 10 |
| ppu_a11 | input | 1 | PPU address bit 11 |
| inner_prg | input | 4 | Inner PRG bank register |
| outer_prg | input | 6 | Outer PRG bank register |
| chr_reg | input | 2 | CHR 8K bank register |
| game_size | input | 2 | Outer window size code (0 = 32K up to 3 = 256K) |
| prg_16k | input | 1 | 1 selects the 16K layouts |
| slot_sel | input | 1 | 16K layout choice: 0 keeps low half fixed, 1 keeps high half fixed |
| mirror | input | 2 | Nametable arrangement code |
| prg_bank | output | 7 | 16K PRG bank number |
| prg_addr | output | 21 | PRG-ROM byte address |
| chr_bank | output | 2 | CHR 8K bank number |
| ciram_a10 | output | 1 | Nametable select line |

## Verification
A wrong mode decode or a wrong mask shows up as a bad prg_bank and prg_addr one cycle after the offending inputs. The bad value appears only for the combinations of cpu_addr[14], slot and size that take the faulty path. For that reason, every mode, slot, size, A14 level and mirroring code is crossed with varied register values. Each output is compared on every cycle against a behavioural model. A fault in the nametable or CHR path appears on the very next clock for the affected mirroring code.

// File: rtl/mcart_bank_pkg.sv
package mcart_bank_pkg;

    typedef enum logic [1:0] {
        PM_32K        = 2'd0,
        PM_16K_LOWFIX = 2'd1,
        PM_16K_HIFIX  = 2'd2
    } prg_mode_t;

    typedef enum logic [1:0] {
        NT_ONE_A = 2'd0,
        NT_ONE_B = 2'd1,
        NT_VERT  = 2'd2,
        NT_HORZ  = 2'd3
    } nt_mode_t;

endpackage

// File: rtl/prg_inner_sel.sv
module prg_inner_sel
    import mcart_bank_pkg::*;
#(
    parameter int INNER_W = 4,
    parameter int OUTER_W = 6
) (
    input  prg_mode_t          mode,
    input  logic               a14,
    input  logic [INNER_W-1:0] inner_prg,
    input  logic [OUTER_W-1:0] outer_prg,
    output logic [INNER_W-1:0] inner_bank
);
    // Fixed half as if 32K mode and the smallest size were forced.
    logic [INNER_W-1:0] fixed_half;
    logic [INNER_W-1:0] wide_bank;

    assign fixed_half = {outer_prg[INNER_W-2:0], a14};
    assign wide_bank  = {inner_prg[INNER_W-2:0], a14};

    always_comb begin
        unique case (mode)
            PM_32K:        inner_bank = wide_bank;
            PM_16K_LOWFIX: inner_bank = a14 ? inner_prg : fixed_half;
            PM_16K_HIFIX:  inner_bank = a14 ? fixed_half : inner_prg;
            default:       inner_bank = wide_bank;
        endcase
    end
endmodule

// File: rtl/prg_outer_merge.sv
module prg_outer_merge #(
    parameter int INNER_W = 4,
    parameter int OUTER_W = 6,
    parameter int SIZE_W  = $clog2(INNER_W),
    parameter int BANK_W  = OUTER_W + 1
) (
    input  logic [SIZE_W-1:0]  game_size,
    input  logic [INNER_W-1:0] inner_bank,
    input  logic [OUTER_W-1:0] outer_prg,
    output logic [BANK_W-1:0]  bank
);
    localparam int PAD_W = BANK_W - INNER_W;

    logic [INNER_W-1:0] imask;
    logic [BANK_W-1:0]  omask;
    logic [BANK_W-1:0]  outer_shift;

    // Inner mask grows by one bit per size step.
    for (genvar k = 0; k < INNER_W; k++) begin : g_imask
        assign imask[k] = (int'(game_size) >= k);
    end

    assign outer_shift = {outer_prg, 1'b0};
    assign omask = ~{{PAD_W{1'b0}}, imask} & {{(BANK_W-1){1'b1}}, 1'b0};
    assign bank  = {{PAD_W{1'b0}}, inner_bank & imask} | (outer_shift & omask);
endmodule

// File: rtl/nt_select.sv
module nt_select
    import mcart_bank_pkg::*;
(
    input  nt_mode_t mode,
    input  logic     ppu_a10,
    input  logic     ppu_a11,
    output logic     ciram_a10
);
    always_comb begin
        unique case (mode)
            NT_ONE_A: ciram_a10 = 1'b0;
            NT_ONE_B: ciram_a10 = 1'b1;
            NT_VERT:  ciram_a10 = ppu_a10;
            NT_HORZ:  ciram_a10 = ppu_a11;
            default:  ciram_a10 = 1'b0;
        endcase
    end
endmodule

// File: rtl/mcart_bank_gen.sv
module mcart_bank_gen
    import mcart_bank_pkg::*;
#(
    parameter int INNER_W = 4,
    parameter int OUTER_W = 6,
    parameter int CHR_W   = 2,
    parameter int OFFS_W  = 14,
    parameter int SIZE_W  = $clog2(INNER_W),
    parameter int BANK_W  = OUTER_W + 1,
    parameter int ADDR_W  = BANK_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OFFS_W:0]   cpu_addr,
    input  logic              ppu_a10,
    input  logic              ppu_a11,
    input  logic [INNER_W-1:0] inner_prg,
    input  logic [OUTER_W-1:0] outer_prg,
    input  logic [CHR_W-1:0]  chr_reg,
    input  logic [SIZE_W-1:0] game_size,
    input  logic              prg_16k,
    input  logic              slot_sel,
    input  logic [1:0]        mirror,
    output logic [BANK_W-1:0] prg_bank,
    output logic [ADDR_W-1:0] prg_addr,
    output logic [CHR_W-1:0]  chr_bank,
    output logic              ciram_a10
);
    prg_mode_t          mode;
    logic [INNER_W-1:0] inner_bank;
    logic [BANK_W-1:0]  bank_c;
    logic               nt_c;
    logic               primed;

    assign mode = !prg_16k ? PM_32K : (slot_sel ? PM_16K_HIFIX : PM_16K_LOWFIX);

    prg_inner_sel #(.INNER_W(INNER_W), .OUTER_W(OUTER_W)) u_inner (
        .mode       (mode),
        .a14        (cpu_addr[OFFS_W]),
        .inner_prg  (inner_prg),
        .outer_prg  (outer_prg),
        .inner_bank (inner_bank)
    );

    prg_outer_merge #(.INNER_W(INNER_W), .OUTER_W(OUTER_W), .SIZE_W(SIZE_W), .BANK_W(BANK_W)) u_merge (
        .game_size  (game_size),
        .inner_bank (inner_bank),
        .outer_prg  (outer_prg),
        .bank       (bank_c)
    );

    nt_select u_nt (
        .mode      (nt_mode_t'(mirror)),
        .ppu_a10   (ppu_a10),
        .ppu_a11   (ppu_a11),
        .ciram_a10 (nt_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prg_bank  <= '0;
            prg_addr  <= '0;
            chr_bank  <= '0;
            ciram_a10 <= 1'b0;
            primed    <= 1'b0;
        end else begin
            prg_bank  <= bank_c;
            prg_addr  <= {bank_c, cpu_addr[OFFS_W-1:0]};
            chr_bank  <= chr_reg;
            ciram_a10 <= nt_c;
            primed    <= 1'b1;
        end
    end

    // R1: outputs cleared while in reset
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (prg_bank == '0 && prg_addr == '0 && chr_bank == '0 && !ciram_a10));

    // R8: byte offset follows the CPU address one cycle later
    a_r8_offset_pass: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> prg_addr[OFFS_W-1:0] == $past(cpu_addr[OFFS_W-1:0]));

    // R3: in the 32K layout the lowest bank bit is A14
    a_r3_wide_a14: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && !$past(prg_16k)) |-> prg_bank[0] == $past(cpu_addr[OFFS_W]));

    // R7: smallest size takes all upper bits from the outer bank
    a_r7_outer_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(game_size) == '0) |-> prg_bank[BANK_W-1:1] == $past(outer_prg));

    // R9: CHR bank passes through
    a_r9_chr_pass: assert property (@(posedge clk) disable iff (!rst_n)
        primed |-> chr_bank == $past(chr_reg));

    // R10: one-screen B drives the select high
    a_r10_screen_b: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && $past(mirror) == 2'd1) |-> ciram_a10);
endmodule

// File: tb/mcart_bank_gen_test.sv
module mcart_bank_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic        ppu_a10 = 1'b0, ppu_a11 = 1'b0;
    logic [3:0]  inner_prg = '0;
    logic [5:0]  outer_prg = '0;
    logic [1:0]  chr_reg = '0;
    logic [1:0]  game_size = '0;
    logic        prg_16k = 1'b0, slot_sel = 1'b0;
    logic [1:0]  mirror = '0;
    logic [6:0]  prg_bank;
    logic [20:0] prg_addr;
    logic [1:0]  chr_bank;
    logic        ciram_a10;

    int checks = 0, fails = 0;
    bit done = 0;
    int exp_bank, exp_addr, exp_chr, exp_nt;
    string bank_tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcart_bank_gen uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
        .inner_prg(inner_prg), .outer_prg(outer_prg), .chr_reg(chr_reg), .game_size(game_size),
        .prg_16k(prg_16k), .slot_sel(slot_sel), .mirror(mirror),
        .prg_bank(prg_bank), .prg_addr(prg_addr), .chr_bank(chr_bank), .ciram_a10(ciram_a10)
    );

    function automatic int model_bank(int g, int p, int s, int a14, int ip, int op);
        int inner, im, om;
        if (p == 0)      inner = (ip * 2 + a14) % 16;
        else if (s == 0) inner = a14 ? ip : (op * 2) % 16;
        else             inner = a14 ? (op * 2 + 1) % 16 : ip;
        im = (2 << g) - 1;
        om = 126 & (127 ^ im);
        return (inner & im) | ((op * 2) & om);
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic apply(int g, int p, int s, int a14, int ip, int op, int m, int v);
        game_size = 2'(g); prg_16k = 1'(p); slot_sel = 1'(s);
        inner_prg = 4'(ip); outer_prg = 6'(op); mirror = 2'(m);
        cpu_addr  = {1'(a14), 14'((v * 1237 + 5) % 16384)};
        chr_reg   = 2'(v); ppu_a10 = v[0]; ppu_a11 = v[1] ^ v[2];
        exp_bank  = model_bank(g, p, s, a14, ip, op);
        exp_addr  = exp_bank * 16384 + int'(cpu_addr[13:0]);
        exp_chr   = v % 4;
        case (m)
            0: exp_nt = 0;
            1: exp_nt = 1;
            2: exp_nt = int'(ppu_a10);
            default: exp_nt = int'(ppu_a11);
        endcase
        if (p == 0 && s == 1) bank_tag = "R6 R3 R7";
        else if (p == 0)      bank_tag = "R3 R7";
        else if (s == 0)      bank_tag = "R4 R7";
        else                  bank_tag = "R5 R7";
    endtask

    task automatic compare_all();
        check(bank_tag, int'(prg_bank), exp_bank);
        check("R8 R2", int'(prg_addr), exp_addr);
        check("R9", int'(chr_bank), exp_chr);
        check("R10", int'(ciram_a10), exp_nt);
    endtask

    initial begin
        // inputs non-zero during reset: outputs must still read zero (R1)
        apply(3, 1, 1, 1, 9, 45, 1, 7);
        repeat (3) begin
            @(negedge clk);
            check("R1 bank", int'(prg_bank), 0);
            check("R1 addr", int'(prg_addr), 0);
            check("R1 nt", int'(ciram_a10), 0);
        end
        rst_n = 1'b1;
        for (int g = 0; g < 4; g++)
            for (int p = 0; p < 2; p++)
                for (int s = 0; s < 2; s++)
                    for (int a = 0; a < 2; a++)
                        for (int m = 0; m < 4; m++)
                            for (int v = 0; v < 16; v++) begin
                                apply(g, p, s, a, (v * 7 + g) % 16, (v * 13 + m * 5 + 63 * a) % 64, m, v + m);
                                @(negedge clk);
                                compare_all();
                            end
        // R6: slot_sel flipped in 32K mode gives the identical result
        apply(2, 0, 0, 1, 11, 37, 3, 6);
        @(negedge clk); compare_all();
        apply(2, 0, 1, 1, 11, 37, 3, 6);
        @(negedge clk); compare_all();
        // R7 corner: all-ones registers at every size
        for (int g = 0; g < 4; g++) begin
            apply(g, 1, 0, 0, 15, 63, 2, 1);
            @(negedge clk); compare_all();
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule